// File: doc/BRIEF.md
# Power-Management Event Interrupt and I/O Window

This block gathers power-management events into a 16-bit event status register and gates them with a 16-bit event enable register. Its level interrupt output is high whenever any enabled, pending event belongs to the fixed set of four interrupt sources: the periodic timer, the global lock, the power button and the real-time clock alarm. It also raises a timer-arm request while the timer event is enabled and not yet pending, so that an external counter knows to keep counting toward its next overflow.

Software reaches the two event registers through a byte-wide I/O bus. They sit in a relocatable 64-byte window. A byte-wide configuration write port sets the window base, and a separate configuration enable bit opens the window. Each I/O access is sorted into one of five access classes: `ACC_NONE` (no access), `ACC_MISS` (outside the window or window closed), `ACC_STS` (status byte), `ACC_EN` (enable byte) and `ACC_RSVD` (unused window offset). A `unique case` on that class drives the read mux and the write strobes. There are no sequential states: every access completes in the cycle it is presented.

Top module: `pm_sci_window`

## Requirements
- R1: After reset the status and enable registers are zero, the window is closed, `sci_o` and `tmr_arm_o` are low, and a read at any I/O address returns 0xFF.
- R2: The window base is configured through byte offsets 0x40 and 0x41. Byte 0x41 holds base bits 15:8. Bits 7:6 of byte 0x40 hold base bits 7:6, and bits 5:0 of that byte are ignored. The window spans base through base+63.
- R3: Bit 0 of configuration byte 0x80 opens the window when 1 and closes it when 0. While the window is closed, reads return 0xFF and writes have no effect.
- R4: Inside the window, offset 0 is status bits 7:0, offset 1 is status bits 15:8, offset 2 is enable bits 7:0 and offset 3 is enable bits 15:8. Offsets 4 to 63 read 0x00 and ignore writes.
- R5: A high level on `evt_i[k]` at a clock edge sets status bit k from that edge on.
- R6: Writing a status byte clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing an enable byte stores the data.
- R7: When an event on bit k and a clearing write to bit k fall in the same cycle, bit k ends up set.
- R8: `sci_o` is high exactly when status AND enable AND 0x0521 is non-zero. The mask selects timer bit 0, global lock bit 5, power button bit 8 and clock alarm bit 10. Because `sci_o` is combinational from the registers, it stays high during a clearing write and falls right after that write's clock edge.
- R9: `tmr_arm_o` is high exactly when enable bit 0 is set and status bit 0 is clear.
- R10: An I/O access outside the open window changes no register, and a read there returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O byte address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational while `io_rd` is high |
| evt_i | input | 16 | Event inputs, one per status bit |
| sci_o | output | 1 | Level system control interrupt |
| tmr_arm_o | output | 1 | Timer arm request |

## Verification
The assertions take for granted that `io_rd` and `io_wr` are never high together and that every input changes only between clock edges. Under those conditions the access class and the event inputs settle before the edge that samples them. The stimulus keeps to this by driving every input on the falling edge and raising at most one strobe per cycle. The only deliberate overlap is an event arriving in the same cycle as a clearing write. The stimulus also never reconfigures the window in the cycle of an I/O access, so window hit and register update always refer to one base value.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int EVT_W      = 16;
    localparam int EVT_BYTES  = EVT_W / 8;
    localparam int LANE_W     = (EVT_BYTES > 1) ? $clog2(EVT_BYTES) : 1;

    localparam int EVT_TMR    = 0;
    localparam int EVT_GLOCK  = 5;
    localparam int EVT_PWRBTN = 8;
    localparam int EVT_RTC    = 10;

    localparam logic [EVT_W-1:0] SCI_MASK =
        (EVT_W'(1) << EVT_TMR)    | (EVT_W'(1) << EVT_GLOCK) |
        (EVT_W'(1) << EVT_PWRBTN) | (EVT_W'(1) << EVT_RTC);

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_MISS,
        ACC_STS,
        ACC_EN,
        ACC_RSVD
    } acc_e;
endpackage

// File: rtl/pm_win_decode.sv
module pm_win_decode #(
    parameter int ADDR_W     = 16,
    parameter int WIN_LG     = 6,
    parameter int CFG_BASE   = 8'h40,
    parameter int CFG_ENABLE = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              win_hit,
    output logic [WIN_LG-1:0] win_ofs
);
    localparam int BASE_HI = ADDR_W - 1;

    logic [BASE_HI:WIN_LG] base_q;
    logic                  win_en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            win_en_q <= 1'b0;
        end else if (cfg_wr) begin
            for (int b = WIN_LG; b <= BASE_HI; b++) begin
                if (cfg_addr == 8'(CFG_BASE + b / 8))
                    base_q[b] <= cfg_wdata[b % 8];
            end
            if (cfg_addr == 8'(CFG_ENABLE))
                win_en_q <= cfg_wdata[0];
        end
    end

    always_comb begin
        win_hit = win_en_q && (io_addr[BASE_HI:WIN_LG] == base_q);
        win_ofs = io_addr[WIN_LG-1:0];
    end

    AST_CLOSED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en_q |-> !win_hit); // R3
    AST_CFG_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == 8'(CFG_ENABLE) && !cfg_wdata[0]) |=> !win_hit); // R3
endmodule

// File: rtl/pm_io_port.sv
module pm_io_port
    import pm_pkg::*;
#(
    parameter int WIN_LG = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    input  logic              win_hit,
    input  logic [WIN_LG-1:0] win_ofs,
    input  logic [EVT_W-1:0]  sts_q,
    input  logic [EVT_W-1:0]  en_q,
    output logic [7:0]        io_rdata,
    output logic [EVT_BYTES-1:0] sts_wr,
    output logic [EVT_BYTES-1:0] en_wr,
    output logic [7:0]        wr_byte
);
    acc_e              acc;
    logic [LANE_W-1:0] lane;

    always_comb begin
        lane = LANE_W'(win_ofs % EVT_BYTES);
        if (!(io_rd || io_wr))
            acc = ACC_NONE;
        else if (!win_hit)
            acc = ACC_MISS;
        else if (int'(win_ofs) < EVT_BYTES)
            acc = ACC_STS;
        else if (int'(win_ofs) < 2 * EVT_BYTES)
            acc = ACC_EN;
        else
            acc = ACC_RSVD;
    end

    always_comb begin
        io_rdata = 8'h00;
        sts_wr   = '0;
        en_wr    = '0;
        wr_byte  = io_wdata;
        unique case (acc)
            ACC_NONE: io_rdata = 8'h00;
            ACC_MISS: io_rdata = io_rd ? 8'hFF : 8'h00;
            ACC_STS: begin
                if (io_rd) io_rdata = sts_q[int'(lane)*8 +: 8];
                if (io_wr) sts_wr[lane] = 1'b1;
            end
            ACC_EN: begin
                if (io_rd) io_rdata = en_q[int'(lane)*8 +: 8];
                if (io_wr) en_wr[lane] = 1'b1;
            end
            ACC_RSVD: io_rdata = 8'h00;
            default:  io_rdata = 8'h00;
        endcase
    end

    AST_MISS_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !win_hit) |-> io_rdata == 8'hFF); // R10
    AST_MISS_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit |-> (sts_wr == '0 && en_wr == '0)); // R10
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sts_wr, en_wr})); // R4
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
    import pm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EVT_W-1:0]     evt_i,
    input  logic [EVT_BYTES-1:0] sts_wr,
    input  logic [EVT_BYTES-1:0] en_wr,
    input  logic [7:0]           wr_byte,
    output logic [EVT_W-1:0]     sts_q,
    output logic [EVT_W-1:0]     en_q
);
    for (genvar g = 0; g < EVT_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sts_q[g*8 +: 8] <= '0;
                en_q[g*8 +: 8]  <= '0;
            end else begin
                if (sts_wr[g])
                    sts_q[g*8 +: 8] <= (sts_q[g*8 +: 8] & ~wr_byte) | evt_i[g*8 +: 8];
                else
                    sts_q[g*8 +: 8] <= sts_q[g*8 +: 8] | evt_i[g*8 +: 8];
                if (en_wr[g])
                    en_q[g*8 +: 8] <= wr_byte;
            end
        end
    end

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((sts_q & $past(evt_i)) == $past(evt_i))); // R5 R7
    AST_W1C_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr[0] && wr_byte[0] && !evt_i[0]) |=> !sts_q[0]); // R6
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == '0) |=> ((sts_q & ~$past(sts_q)) == '0)); // R5
endmodule

// File: rtl/pm_sci_gen.sv
module pm_sci_gen
    import pm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] sts_q,
    input  logic [EVT_W-1:0] en_q,
    output logic             sci_o,
    output logic             tmr_arm_o
);
    logic [EVT_W-1:0] live;

    always_comb begin
        live      = sts_q & en_q & SCI_MASK;
        sci_o     = |live;
        tmr_arm_o = en_q[EVT_TMR] & ~sts_q[EVT_TMR];
    end

    AST_UNMASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_q & SCI_MASK) == '0) |-> !sci_o); // R8
    AST_ARM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_arm_o |-> !(sci_o && live == (EVT_W'(1) << EVT_TMR))); // R9
endmodule

// File: rtl/pm_sci_window.sv
module pm_sci_window
    import pm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WIN_LG = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic [EVT_W-1:0]  evt_i,
    output logic              sci_o,
    output logic              tmr_arm_o
);
    logic                 win_hit;
    logic [WIN_LG-1:0]    win_ofs;
    logic [EVT_W-1:0]     sts_q;
    logic [EVT_W-1:0]     en_q;
    logic [EVT_BYTES-1:0] sts_wr;
    logic [EVT_BYTES-1:0] en_wr;
    logic [7:0]           wr_byte;

    pm_win_decode #(.ADDR_W(ADDR_W), .WIN_LG(WIN_LG)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .io_addr(io_addr), .win_hit(win_hit), .win_ofs(win_ofs)
    );

    pm_io_port #(.WIN_LG(WIN_LG)) u_port (
        .clk(clk), .rst_n(rst_n),
        .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
        .win_hit(win_hit), .win_ofs(win_ofs),
        .sts_q(sts_q), .en_q(en_q), .io_rdata(io_rdata),
        .sts_wr(sts_wr), .en_wr(en_wr), .wr_byte(wr_byte)
    );

    pm_evt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .sts_wr(sts_wr), .en_wr(en_wr), .wr_byte(wr_byte),
        .sts_q(sts_q), .en_q(en_q)
    );

    pm_sci_gen u_sci (
        .clk(clk), .rst_n(rst_n), .sts_q(sts_q), .en_q(en_q),
        .sci_o(sci_o), .tmr_arm_o(tmr_arm_o)
    );

    AST_EVT_RAISES_SCI: assert property (@(posedge clk) disable iff (!rst_n)
        (((evt_i & en_q & SCI_MASK) != '0) && !io_wr) |=> sci_o); // R8
    AST_TMR_EVT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[EVT_TMR] |=> !tmr_arm_o); // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!sci_o && !tmr_arm_o)); // R1
endmodule

// File: tb/pm_sci_window_tb.sv
`timescale 1ns/1ps
module pm_sci_window_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [15:0] evt_i = '0;
    logic        sci_o;
    logic        tmr_arm_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    localparam logic [15:0] BASE = 16'h12C0;
    localparam int NV = 8;
    // {enable, events, expected sci, expected arm}
    localparam logic [33:0] VEC [NV] = '{
        {16'h0001, 16'h0001, 1'b1, 1'b0},
        {16'h0001, 16'h0000, 1'b0, 1'b1},
        {16'h0020, 16'h0020, 1'b1, 1'b0},
        {16'h0100, 16'h0100, 1'b1, 1'b0},
        {16'h0400, 16'h0400, 1'b1, 1'b0},
        {16'h0002, 16'h0002, 1'b0, 1'b0},
        {16'hFFFF, 16'h8A5E, 1'b0, 1'b1},
        {16'h0500, 16'h0121, 1'b1, 1'b0}
    };

    pm_sci_window dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .evt_i(evt_i), .sci_o(sci_o), .tmr_arm_o(tmr_arm_o)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk); io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk); io_rd = 1'b1; io_addr = a;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] e);
        @(negedge clk); evt_i = e;
        @(negedge clk); evt_i = '0;
    endtask

    task automatic clear_all();
        io_write(BASE + 16'd0, 8'hFF);
        io_write(BASE + 16'd1, 8'hFF);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] lo;
        logic [7:0] hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 sci", {15'd0, sci_o}, 16'd0);
        chk("R1 arm", {15'd0, tmr_arm_o}, 16'd0);
        io_read(16'h0000, rd); chk("R1 read closed", {8'd0, rd}, 16'h00FF);

        // R2: base from 0x40/0x41, low bits masked
        cfg_write(8'h40, 8'hFF);
        cfg_write(8'h41, 8'h12);
        // R3: window still closed
        io_read(BASE, rd); chk("R3 closed read", {8'd0, rd}, 16'h00FF);
        cfg_write(8'h80, 8'h01);
        io_read(BASE + 16'd2, rd); chk("R1 enable reset", {8'd0, rd}, 16'h0000);
        io_read(BASE + 16'd63, rd); chk("R2 window top", {8'd0, rd}, 16'h0000);
        io_read(BASE + 16'd64, rd); chk("R2 above window", {8'd0, rd}, 16'h00FF);
        io_read(BASE - 16'd1, rd); chk("R2 below window", {8'd0, rd}, 16'h00FF);

        // R4: reserved offset
        io_write(BASE + 16'd5, 8'hAA);
        io_read(BASE + 16'd5, rd); chk("R4 reserved", {8'd0, rd}, 16'h0000);

        // R10: outside write ignored
        io_write(16'h1302, 8'hFF);
        io_read(BASE + 16'd2, rd); chk("R10 outside write", {8'd0, rd}, 16'h0000);

        // Vector table: R5 R8 R9
        for (int i = 0; i < NV; i++) begin
            logic [15:0] en_v;
            logic [15:0] ev_v;
            en_v = VEC[i][33:18];
            ev_v = VEC[i][17:2];
            clear_all();
            io_write(BASE + 16'd2, en_v[7:0]);
            io_write(BASE + 16'd3, en_v[15:8]);
            pulse(ev_v);
            io_read(BASE + 16'd0, lo);
            io_read(BASE + 16'd1, hi);
            chk($sformatf("R5 vec%0d status", i), {hi, lo}, ev_v);
            chk($sformatf("R8 vec%0d sci", i), {15'd0, sci_o}, {15'd0, VEC[i][1]});
            chk($sformatf("R9 vec%0d arm", i), {15'd0, tmr_arm_o}, {15'd0, VEC[i][0]});
        end

        // R4 enable readback of the last vector
        io_read(BASE + 16'd3, rd); chk("R4 enable hi", {8'd0, rd}, 16'h0005);

        // R6: W1C and zero writes
        clear_all();
        io_write(BASE + 16'd2, 8'h01);
        io_write(BASE + 16'd3, 8'h00);
        pulse(16'h0021);
        io_write(BASE + 16'd0, 8'h00);
        io_read(BASE + 16'd0, rd); chk("R6 zero write", {8'd0, rd}, 16'h0021);
        io_write(BASE + 16'd0, 8'h20);
        io_read(BASE + 16'd0, rd); chk("R6 w1c", {8'd0, rd}, 16'h0001);
        chk("R9 disarmed", {15'd0, tmr_arm_o}, 16'd0);

        // R8: sci holds during clearing write, falls after its edge
        @(negedge clk); io_wr = 1'b1; io_addr = BASE; io_wdata = 8'h01;
        #1 chk("R8 sci during write", {15'd0, sci_o}, 16'd1);
        @(negedge clk); io_wr = 1'b0;
        #1 chk("R8 sci after write", {15'd0, sci_o}, 16'd0);
        chk("R9 rearmed", {15'd0, tmr_arm_o}, 16'd1);

        // R7: event and clear together
        @(negedge clk); io_wr = 1'b1; io_addr = BASE; io_wdata = 8'h01; evt_i = 16'h0001;
        @(negedge clk); io_wr = 1'b0; evt_i = '0;
        io_read(BASE + 16'd0, rd); chk("R7 event wins", {8'd0, rd}, 16'h0001);

        // R3: closing the window
        cfg_write(8'h80, 8'h00);
        io_read(BASE, rd); chk("R3 reclosed read", {8'd0, rd}, 16'h00FF);
        io_write(BASE, 8'h01);
        cfg_write(8'h80, 8'h01);
        io_read(BASE, rd); chk("R3 closed write ignored", {8'd0, rd}, 16'h0001);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule